// File: doc/BRIEF.md
# Dual Serial Card Bus Interface

This block sits between an 8-bit-addressed I/O bus and two asynchronous serial controllers on one card. It compares the upper port address bits with a configured base, and on a hit during an input or output cycle it raises a card select. It then steers one of the two controllers by address bit 1 and passes address bit 0 through as the register select. It also produces the controllers' read/write line and an enable for the buffer that carries controller data onto the system data bus.

Each access to the card is stretched by one wait flop. The flop sets on the first clock edge of a matching access and pulls the processor ready line low. It clears when the processor reports that it has entered its wait state. A base value claims four consecutive ports: two registers in each of two controllers.

Top module: `sio_bus_iface`

## Requirements
- R1: `card_sel` is 1 exactly when `io_rd` or `io_wr` is 1 and `io_addr[7:2]` equals `base_sel`; otherwise it is 0.
- R2: `reg_sel` always equals `io_addr[0]`.
- R3: `chip_sel[0]` is 1 exactly when `card_sel` is 1 and `io_addr[1]` is 0, and `chip_sel[1]` is 1 exactly when `card_sel` is 1 and `io_addr[1]` is 1, so at most one bit is set.
- R4: `rd_wr_n` is 0 (write) exactly when `card_sel` is 1 and `io_wr` is 1; otherwise it is 1 (read).
- R5: `buf_en` is 1 exactly when `card_sel` is 1, `io_rd` is 1 and `io_wr` is 0. It is 0 for output cycles and for unmatched addresses.
- R6: At a clock edge where the access matches, did not match at the previous edge, and `wait_ack` is 0, the wait flop sets, and `cpu_ready` is 0 from that edge on. Unmatched accesses never lower `cpu_ready`.
- R7: At any clock edge where `wait_ack` is 1, the wait flop clears and `cpu_ready` is 1 after that edge. A clear takes priority over a set at the same edge.
- R8: An access held across many cycles sets the wait flop only once. A new wait requires the match to be absent for at least one clock edge.
- R9: While `rst_n` is 0 at a clock edge, the wait flop and the match history clear, so `cpu_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | Input (IN) cycle strobe, active high |
| io_wr | input | 1 | Output (OUT) cycle strobe, active high |
| wait_ack | input | 1 | Processor wait acknowledge, active high |
| base_sel | input | 6 | Card base address, compared with address bits 7..2 |
| card_sel | output | 1 | Card addressed during an I/O cycle |
| chip_sel | output | 2 | Per-controller select, one bit per controller |
| reg_sel | output | 1 | Register select to both controllers |
| rd_wr_n | output | 1 | Controller direction, 1 = read, 0 = write |
| buf_en | output | 1 | Read buffer enable toward the system data bus |
| cpu_ready | output | 1 | Processor ready, 0 while the wait flop is set |

## Verification
The bench uses the default widths: an 8-bit address and two controllers. With these values all four ports of one card can be reached, both polarities of the address-bit-1 split are visited, and the neighbouring ports just above and below the window can be tested for misses. Wait timing is exercised with the acknowledge arriving late, arriving on the same edge as a new access, and with an access held across several edges. This covers the single-set behaviour and the rule that a clear wins over a set.

// File: rtl/sio_bus_pkg.sv
// Shared types for the serial card bus interface.
// Assumes at most one of the IN/OUT strobes is meaningful per cycle.
package sio_bus_pkg;
    // Classification of the current bus cycle as seen by this card.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/sio_port_decode.sv
// Port address decoder: compares the upper address bits against the base
// and classifies the cycle. Assumes an OUT strobe dominates if both are high.
module sio_port_decode
    import sio_bus_pkg::*;
#(
    parameter int BASE_W = 6
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic              addr_lsb,
    input  logic [BASE_W-1:0] base_sel,
    input  logic              io_rd,
    input  logic              io_wr,
    output acc_kind_t         acc_kind,
    output logic              reg_sel
);
    logic addr_hit;

    // Compare the port window and classify the cycle.
    always_comb begin
        addr_hit = (addr_hi == base_sel);
        if (!addr_hit)  acc_kind = ACC_NONE;
        else if (io_wr) acc_kind = ACC_WRITE;
        else if (io_rd) acc_kind = ACC_READ;
        else            acc_kind = ACC_NONE;
    end

    // Register select follows the lowest address bit unconditionally.
    assign reg_sel = addr_lsb;
endmodule

// File: rtl/sio_chip_split.sv
// Splits the card select into one select per serial controller using the
// controller-index address bits. Assumes NUM_CHIPS <= 2**CHIP_BITS.
module sio_chip_split #(
    parameter int NUM_CHIPS = 2,
    parameter int CHIP_BITS = 1
) (
    input  logic                 card_sel,
    input  logic [CHIP_BITS-1:0] chip_idx,
    output logic [NUM_CHIPS-1:0] chip_sel
);
    // One comparator per controller; index 0 is the inverted-polarity one.
    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
        assign chip_sel[i] = card_sel && (chip_idx == CHIP_BITS'(i));
    end
endmodule

// File: rtl/sio_wait_ctl.sv
// Wait-state flop: sets at the first edge of a matching access, clears
// when the processor acknowledges its wait state. Assumes wait_ack is
// synchronous to clk. The clear dominates the set.
module sio_wait_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic wait_ack,
    output logic ready_o
);
    logic wait_q;
    logic match_q;
    logic start;

    // A new access is a match not present at the previous edge.
    assign start = match && !match_q;

    // Track match history and the wait flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            match_q <= match;
            if (wait_ack)   wait_q <= 1'b0;
            else if (start) wait_q <= 1'b1;
        end
    end

    assign ready_o = !wait_q;

    assert_wait_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wait_ack) |=> !ready_o);

    assert_wait_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_ack |=> ready_o);

    assert_hold_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && match_q && ready_o) |=> ready_o);

    assert_no_miss_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && ready_o) |=> ready_o);
endmodule

// File: rtl/sio_bus_iface.sv
// Bus-side interface of a dual serial card: port decode, per-controller
// select, direction, read buffer enable and one stretched wait per access.
// Assumes IN and OUT strobes are not asserted together in normal use.
module sio_bus_iface
    import sio_bus_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CHIPS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    io_addr,
    input  logic                                 io_rd,
    input  logic                                 io_wr,
    input  logic                                 wait_ack,
    input  logic [ADDR_W-2-((NUM_CHIPS>1)?$clog2(NUM_CHIPS):1):0] base_sel,
    output logic                                 card_sel,
    output logic [NUM_CHIPS-1:0]                 chip_sel,
    output logic                                 reg_sel,
    output logic                                 rd_wr_n,
    output logic                                 buf_en,
    output logic                                 cpu_ready
);
    localparam int CHIP_BITS = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
    localparam int PORT_BITS = 1 + CHIP_BITS;
    localparam int BASE_W    = ADDR_W - PORT_BITS;

    acc_kind_t acc_kind;

    sio_port_decode #(.BASE_W(BASE_W)) u_decode (
        .addr_hi  (io_addr[ADDR_W-1:PORT_BITS]),
        .addr_lsb (io_addr[0]),
        .base_sel (base_sel),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .acc_kind (acc_kind),
        .reg_sel  (reg_sel)
    );

    // Derive card-level strobes from the cycle class.
    always_comb begin
        card_sel = (acc_kind != ACC_NONE);
        rd_wr_n  = (acc_kind != ACC_WRITE);
        buf_en   = (acc_kind == ACC_READ);
    end

    sio_chip_split #(.NUM_CHIPS(NUM_CHIPS), .CHIP_BITS(CHIP_BITS)) u_split (
        .card_sel (card_sel),
        .chip_idx (io_addr[PORT_BITS-1:1]),
        .chip_sel (chip_sel)
    );

    sio_wait_ctl u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (card_sel),
        .wait_ack (wait_ack),
        .ready_o  (cpu_ready)
    );

    assert_sel_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        card_sel |-> (io_rd || io_wr));

    assert_one_chip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel) && ((chip_sel != '0) == card_sel));

    assert_write_only_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_wr_n |-> (io_wr && chip_sel != '0));

    assert_buf_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> (io_rd && !io_wr && rd_wr_n && chip_sel != '0));
endmodule

// File: tb/sim_sio_bus_iface.sv
module sim_sio_bus_iface;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic       io_rd = 1'b0, io_wr = 1'b0, wait_ack = 1'b0;
    logic [5:0] base_sel = 6'h2A;
    logic       card_sel, reg_sel, rd_wr_n, buf_en, cpu_ready;
    logic [1:0] chip_sel;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    sio_bus_iface u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .wait_ack(wait_ack), .base_sel(base_sel),
        .card_sel(card_sel), .chip_sel(chip_sel), .reg_sel(reg_sel),
        .rd_wr_n(rd_wr_n), .buf_en(buf_en), .cpu_ready(cpu_ready)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive(logic [7:0] a, logic rd, logic wr, logic ack);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; wait_ack = ack;
        #1;
    endtask

    // End an access: bus idle with acknowledge for one edge, then quiet.
    task automatic release_bus();
        drive(8'h00, 1'b0, 1'b0, 1'b1);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        chk("R9 ready in reset", cpu_ready, 1);
        chk("R1 idle card_sel", card_sel, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9 ready after reset", cpu_ready, 1);
    endtask

    task automatic t_decode(logic is_wr);
        for (int p = 0; p < 4; p++) begin
            logic [7:0] a;
            a = {6'h2A, 2'(p)};
            drive(a, !is_wr, is_wr, 1'b0);
            chk("R1 card_sel on hit", card_sel, 1);
            chk("R2 reg_sel", reg_sel, a[0]);
            chk("R3 chip_sel", chip_sel, a[1] ? 2'b10 : 2'b01);
            chk("R4 rd_wr_n", rd_wr_n, is_wr ? 0 : 1);
            chk("R5 buf_en", buf_en, is_wr ? 0 : 1);
            release_bus();
        end
    endtask

    task automatic t_miss();
        drive(8'hAC, 1'b1, 1'b0, 1'b0);
        chk("R1 miss above", card_sel, 0);
        chk("R3 miss chip_sel", chip_sel, 0);
        chk("R5 miss buf_en", buf_en, 0);
        chk("R2 reg_sel on miss", reg_sel, 0);
        drive(8'hA7, 1'b0, 1'b1, 1'b0);
        chk("R1 miss below", card_sel, 0);
        chk("R4 unmatched out", rd_wr_n, 1);
        chk("R6 miss no wait", cpu_ready, 1);
        drive(8'hA9, 1'b0, 1'b0, 1'b0);
        chk("R1 hit without strobe", card_sel, 0);
        chk("R2 reg_sel no strobe", reg_sel, 1);
        chk("R6 no strobe no wait", cpu_ready, 1);
    endtask

    task automatic t_wait();
        drive(8'hAA, 1'b1, 1'b0, 1'b0);
        chk("R6 ready before edge", cpu_ready, 1);
        drive(8'hAA, 1'b1, 1'b0, 1'b0);
        chk("R6 ready low", cpu_ready, 0);
        drive(8'hAA, 1'b1, 1'b0, 1'b0);
        chk("R6 ready held low", cpu_ready, 0);
        drive(8'hAA, 1'b1, 1'b0, 1'b1);
        drive(8'hAA, 1'b1, 1'b0, 1'b0);
        chk("R7 ready released", cpu_ready, 1);
        drive(8'hAA, 1'b1, 1'b0, 1'b0);
        chk("R8 held access no rewait", cpu_ready, 1);
        drive(8'hAA, 1'b0, 1'b0, 1'b0);
        chk("R8 gap ready", cpu_ready, 1);
        drive(8'hAB, 1'b0, 1'b1, 1'b0);
        drive(8'hAB, 1'b0, 1'b1, 1'b0);
        chk("R8 new access waits", cpu_ready, 0);
        release_bus();
        chk("R7 ready after release", cpu_ready, 1);
    endtask

    task automatic t_clear_wins();
        drive(8'hA8, 1'b1, 1'b0, 1'b1);
        drive(8'hA8, 1'b1, 1'b0, 1'b0);
        chk("R7 clear beats set", cpu_ready, 1);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        chk("R7 quiet ready", cpu_ready, 1);
    endtask

    initial begin
        t_reset();
        t_decode(1'b0);
        t_decode(1'b1);
        t_miss();
        t_wait();
        t_clear_wins();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule